// File: doc/BRIEF.md
# Non-Maskable Interrupt Watchdog Timer

The block watches for software that has stopped running properly. It counts cycles of a slow timebase, which reaches it as a one-cycle enable pulse in the system clock domain. If software does not restart the count within a set period, the block sends a non-maskable interrupt request to the interrupt controller as a single-cycle pulse. The count then starts again from zero, so the request comes back once per period for as long as software does not service the watchdog.

Software uses one byte-wide control register on a simple bus (address, write strobe, write data, combinational read data). Bit 7 turns the watchdog on or off, and writing 1 to bit 2 restarts it. The period is a static power-of-two parameter. Inside, a free-running prescaler divides the timebase by a quarter of the period, and a 2-bit stage counter counts those quarter ticks. A restart clears only the stage counter. Because of this, the timeout after a restart is between three quarters of the period and the full period.

Top module: `nmi_watchdog`

## Requirements
- R1: After reset the enable bit (bit 7) is 1, so counting starts without any software write, and the control register reads 0x80.
- R2: Writing bit 7 of the control register sets the enable. While it is 0, neither the prescaler nor the stage counter moves and irq_o stays low. After it is set back to 1, counting continues from the held state.
- R3: A write to the control register with bit 2 = 1 clears the stage counter at that clock edge. Counting goes on from the next timebase tick.
- R4: A write with bit 2 = 0 does not restart the count. Bit 2 and every bit other than bit 7 read as 0. Reads at other addresses return 0x00, and writes at other addresses change nothing.
- R5: If no restart happens, irq_o goes high in the cycle after the clock edge that samples the PERIOD-th enabled timebase tick since reset.
- R6: irq_o is high for exactly one cycle per timeout. If no restart happens, the next pulse comes PERIOD enabled ticks later.
- R7: If a restart write falls in the same cycle as the tick that would time out, the restart wins and no pulse is issued.
- R8: Only cycles with tick_i high and the enable set advance the count.
- R9: A restart does not clear the prescaler. Because of this, the next pulse follows between 3*PERIOD/4+1 and PERIOD enabled ticks after the restart, depending on the prescaler phase at the time of the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase enable, one cycle per timebase period |
| addr_i | input | ADDR_W | Register address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Non-maskable interrupt request pulse |

## Verification
A wrong prescaler phase or stage value shows up only as an interrupt pulse at the wrong time. The error can stay hidden for up to a full period, so the bench checks irq_o in every cycle against a model built from the requirements, and not only at the expected pulse times. Restarts are placed at the first and last prescaler phases, and one is placed on the final tick. These cases show within a quarter period whether the restart clears the wrong counter or loses the race with the tick. An enable bit that is not honoured shows up as a pulse during a long disabled window, or as a wrong read-back of 0x80 or 0x00.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W  = 8;
  localparam int EN_BIT  = 7;
  localparam int RST_BIT = 2;
  localparam int STAGE_W = 2;
  typedef logic [STAGE_W-1:0] stage_t;
  localparam stage_t STAGE_LAST = stage_t'((1 << STAGE_W) - 1);
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic              restart_o
);
  logic sel, wr_sel, en_q;
  logic unused_wdata;

  assign sel          = (addr_i == CTRL_ADDR);
  assign wr_sel       = wr_i && sel;
  assign unused_wdata = ^{wdata_i[DATA_W-1:EN_BIT+1], wdata_i[EN_BIT-1:RST_BIT+1],
                          wdata_i[RST_BIT-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= 1'b1;
    else if (wr_sel) en_q <= wdata_i[EN_BIT];
  end

  assign en_o      = en_q;
  assign restart_o = wr_sel && wdata_i[RST_BIT];

  always_comb begin
    rdata_o = '0;
    if (sel) rdata_o[EN_BIT] = en_q;
  end

  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel |=> (en_o == $past(wdata_i[EN_BIT]))) else $error("en write"); // R2
  AST_FOREIGN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel) |=> $stable(en_o)) else $error("foreign write"); // R4
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int QUARTER = 4,
  localparam int CNT_W  = (QUARTER > 1) ? $clog2(QUARTER) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic             qtick_o,
  output logic [CNT_W-1:0] cnt_o
);
  generate
    if (QUARTER == 1) begin : g_direct
      assign qtick_o = run_i;
      assign cnt_o   = '0;
    end else begin : g_count
      localparam logic [CNT_W-1:0] LAST = CNT_W'(QUARTER - 1);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    cnt_q <= '0;
        else if (run_i) cnt_q <= cnt_q + 1'b1;  // power of two: natural wrap
      end
      assign qtick_o = run_i && (cnt_q == LAST);
      assign cnt_o   = cnt_q;

      AST_PRE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> $stable(cnt_q)) else $error("prescaler moved"); // R8
    end
  endgenerate
endmodule

// File: rtl/wdt_stage_ctr.sv
module wdt_stage_ctr
  import wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qtick_i,
  input  logic clear_i,
  output logic fire_o
);
  stage_t stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stage_q <= '0;
    else if (clear_i) stage_q <= '0;
    else if (qtick_i) stage_q <= stage_q + 1'b1;
  end

  // restart has priority over the wrapping tick
  assign fire_o = qtick_i && !clear_i && (stage_q == STAGE_LAST);

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (stage_q == '0)) else $error("clear"); // R3
  AST_FIRE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (stage_q == '0)) else $error("wrap"); // R6
endmodule

// File: rtl/nmi_watchdog.sv
module nmi_watchdog
  import wdt_pkg::*;
#(
  parameter int                PERIOD    = 131072,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h40,
  localparam int QUARTER = PERIOD / 4,
  localparam int CNT_W   = (QUARTER > 1) ? $clog2(QUARTER) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic en, restart, run, qtick, fire, irq_q;
  logic [CNT_W-1:0] pre_cnt;

  initial begin
    assert (PERIOD >= 4 && (PERIOD & (PERIOD - 1)) == 0) else $error("PERIOD must be 2^n >= 4");
  end

  wdt_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i, .rdata_o,
    .en_o(en), .restart_o(restart)
  );

  assign run = en && tick_i;

  wdt_prescaler #(.QUARTER(QUARTER)) u_pre (
    .clk_i, .rst_ni, .run_i(run), .qtick_o(qtick), .cnt_o(pre_cnt)
  );

  wdt_stage_ctr u_stage (
    .clk_i, .rst_ni, .qtick_i(qtick), .clear_i(restart), .fire_o(fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= fire;
  end
  assign irq_o = irq_q;

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o) else $error("pulse width"); // R6
  AST_OFF_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !irq_o) else $error("irq while disabled"); // R2
  AST_RESTART_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> !irq_o) else $error("irq after restart"); // R7
  AST_RESTART_KEEPS_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && !run) |=> $stable(pre_cnt)) else $error("prescaler cleared"); // R9
  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(run)) else $error("irq without tick"); // R8
endmodule

// File: tb/nmi_watchdog_bench.sv
module nmi_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 16;
  localparam int Q          = PERIOD / 4;
  localparam logic [7:0] CTRL = 8'h40;
  localparam logic [7:0] OTHER = 8'h41;

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, wr_i = 1'b0, irq_o;
  logic [7:0] addr_i = '0, wdata_i = '0, rdata_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_watchdog #(.PERIOD(PERIOD), .ADDR_W(8), .CTRL_ADDR(CTRL)) u_nmi_watchdog (
    .clk_i(clk), .rst_ni, .tick_i, .addr_i, .wr_i, .wdata_i, .rdata_o, .irq_o
  );

  int errors = 0, checks = 0;
  bit done = 0;
  bit    exp_q[$];
  string req_q[$];
  int m_phase = 0, m_stage = 0;
  bit m_en = 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: drives one cycle and pushes the expected irq_o after that edge
  task automatic step(bit tk, bit wr, logic [7:0] a, logic [7:0] d, string req);
    bit qt = 0, ex = 0, rs;
    @(negedge clk);
    tick_i = tk; wr_i = wr; addr_i = a; wdata_i = d;
    rs = wr && (a == CTRL) && d[2];
    if (m_en && tk) begin
      m_phase++;
      if (m_phase == Q) begin m_phase = 0; qt = 1; end
    end
    if (rs) m_stage = 0;
    else if (qt) begin
      if (m_stage == 3) ex = 1;
      m_stage = (m_stage + 1) % 4;
    end
    if (wr && a == CTRL) m_en = d[7];
    exp_q.push_back(ex);
    req_q.push_back(req);
  endtask

  task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string req);
    step(0, 0, a, 8'h00, req);
    #1;
    chk(rdata_o === exp, req, "rdata_o", int'(rdata_o), int'(exp));
  endtask

  task automatic run_to_phase(int ph, int st, string req);
    for (int k = 0; k < 64; k++) begin
      if (m_phase == ph && (st < 0 || m_stage == st)) break;
      step(1, 0, 8'h00, 8'h00, req);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        bit e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(irq_o === e, r, "irq_o", int'(irq_o), int'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(irq_o === 1'b0, "R1", "irq_o in reset", int'(irq_o), 0);
    rst_ni = 1'b1;
    rd_chk(CTRL, 8'h80, "R1");
    rd_chk(OTHER, 8'h00, "R4");
    // R5 / R6: free run, pulses at 16 and 32 ticks
    for (int i = 0; i < 40; i++) step(1, 0, 8'h00, 8'h00, "R5_R6");
    // R3: serviced often enough, no pulse
    step(1, 1, CTRL, 8'h84, "R3");
    for (int j = 0; j < 6; j++) begin
      for (int i = 0; i < 9; i++) step(1, 0, 8'h00, 8'h00, "R3");
      step(1, 1, CTRL, 8'h84, "R3");
    end
    rd_chk(CTRL, 8'h80, "R4");
    // R4: bit2 = 0 does not restart
    step(1, 1, CTRL, 8'h80, "R4");
    for (int i = 0; i < 20; i++) step(1, 0, 8'h00, 8'h00, "R4");
    // R7: restart on the final tick
    run_to_phase(Q - 1, 3, "R7");
    step(1, 1, CTRL, 8'h84, "R7");
    for (int i = 0; i < 8; i++) step(1, 0, 8'h00, 8'h00, "R7");
    // R9: restart at the last prescaler phase -> short timeout
    run_to_phase(Q - 1, -1, "R9");
    step(0, 1, CTRL, 8'h84, "R9");
    for (int i = 0; i < 20; i++) step(1, 0, 8'h00, 8'h00, "R9");
    // R9: restart at phase 0 -> full timeout
    run_to_phase(0, -1, "R9");
    step(0, 1, CTRL, 8'h84, "R9");
    for (int i = 0; i < 20; i++) step(1, 0, 8'h00, 8'h00, "R9");
    // R2: disable, hold, re-enable
    step(1, 1, CTRL, 8'h00, "R2");
    for (int i = 0; i < 50; i++) step(1, 0, 8'h00, 8'h00, "R2");
    rd_chk(CTRL, 8'h00, "R2");
    step(1, 1, CTRL, 8'h80, "R2");
    for (int i = 0; i < 40; i++) step(1, 0, 8'h00, 8'h00, "R2");
    rd_chk(CTRL, 8'h80, "R2");
    // R8: sparse timebase
    for (int i = 0; i < 120; i++) step((i % 3) == 0, 0, 8'h00, 8'h00, "R8");
    // R4: write to another address ignored
    step(1, 1, OTHER, 8'h04, "R4");
    rd_chk(CTRL, 8'h80, "R4");
    rd_chk(OTHER, 8'h00, "R4");
    for (int i = 0; i < 40; i++) step(1, 0, 8'h00, 8'h00, "R4");
    step(0, 0, 8'h00, 8'h00, "R6");
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule